// File: doc/BRIEF.md
# Two-Phase GPIO Register Write Master

This block owns a 32-bit general-purpose pin bus that fans out to four small configuration targets, each holding eight write-only registers of five bits. The targets have no clock and no strobe: a target latches a register when its own enable bit rises while a register index and a data value are already stable on the bus. The block accepts one write request at a time (a target number, a register index and a data value) and plays it out as two bus phases. First it places the index and data with every enable low. It holds that phase for a programmable number of clock cycles, then repeats the same index and data with the single enable of the chosen target set.

The enable bits and the register index share a 7-bit address field on bus bits 15:9. The enable for target 1 is the top bit of that field and the enable for target 4 is the lowest enable bit. The data field is on bus bits 31:27. A write changes only those two fields. Five further output bits are set one at a time through a separate field-write port. Eight input bits can be picked out through a field-read port. Writes and field updates are serialized, and a register write has priority. A target number outside 1 to 4 is refused with a one-cycle error pulse and leaves the bus untouched.

Top module: `gpio_wr_master`

## Requirements
- R1: After reset, gpio_out is all zeros (every enable low), req_ready is 1, and wr_done and wr_err are 0.
- R2: In the cycle after a valid request is accepted, bus bits 14:12 and bit 15 are 0, bits 11:9 carry the register index and bits 31:27 carry the data. This phase stays on the bus for exactly SETUP_CYC cycles.
- R3: After phase 1, the bus shows the same index and data with exactly one enable set: target 1 sets bit 15, target 2 bit 14, target 3 bit 13 and target 4 bit 12. At no time is more than one of bits 15:12 set.
- R4: req_ready is low from the cycle after acceptance through the first cycle of phase 2. wr_done is high for exactly one cycle, the cycle after that, and req_ready returns high in the same cycle.
- R5: A request with target 0, 5, 6 or 7 is accepted but not executed. wr_err is high for the next cycle only, gpio_out does not change, wr_done stays low and req_ready stays high.
- R6: A register write leaves every bus bit outside 15:9 and 31:27 at its previous value.
- R7: A field write with fw_sel 0, 1, 2, 3 or 4 loads fw_value into bus bit 0, 1, 17, 18 or 26 respectively, visible the cycle after acceptance. fw_sel 5 to 7 changes nothing.
- R8: fw_ready is low while a register write is in progress and while req_valid is high. A field write offered then is not applied and does not alter the bus.
- R9: fr_value shows, without a clock, input bit 2, 3, 4, 5, 19, 20, 24 or 25 for fr_sel 0 to 7.
- R10: gpio_oe is the fixed direction mask 0xFC06FE03 (1 = driven).
- R11: After a write completes, its enable bit stays set until the phase 1 of the next valid write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register write request present |
| req_ready | output | 1 | Master can accept a request |
| req_target | input | 3 | Target number, valid 1 to 4 |
| req_reg | input | 3 | Register index inside the target |
| req_data | input | 5 | Value to write |
| wr_done | output | 1 | One-cycle pulse at the end of a write |
| wr_err | output | 1 | One-cycle pulse for a refused target number |
| fw_valid | input | 1 | Single-bit field write request |
| fw_ready | output | 1 | Field write can be accepted |
| fw_sel | input | 3 | Output field selector |
| fw_value | input | 1 | Value for the selected output bit |
| fr_sel | input | 3 | Input field selector |
| fr_value | output | 1 | Selected input bit |
| gpio_in | input | 32 | Sampled pin levels |
| gpio_out | output | 32 | Driven pin levels |
| gpio_oe | output | 32 | Pin direction, 1 = output |

## Verification
The hardest situation to reach is a field write that competes with a register write already under way, since it must neither land on the bus nor disturb the address and data fields during the setup window. The bench raises fw_valid one cycle into phase 1 with a value opposite to the bit it targets. It checks that fw_ready is low, that the bit has not moved and that phase 1 is intact, and it drops the request before the write completes. Enable persistence is reached by two writes in a row, with the bus sampled between them and again inside the second phase 1.

// File: rtl/gpio_wr_pkg.sv
// Shared constants, types and lookup functions for the GPIO register write master.
// Assumes a 32-bit pin bus with the address field at 15:9 and data at 31:27.
package gpio_wr_pkg;

    localparam int BUS_W    = 32;
    localparam int N_TGT    = 4;
    localparam int REG_W    = 3;
    localparam int ADDR_W   = N_TGT + REG_W;
    localparam int ADDR_LSB = 9;
    localparam int DATA_W   = 5;
    localparam int DATA_LSB = 27;
    localparam int TGT_W    = 3;
    localparam int SEL_W    = 3;
    localparam int IDX_W    = $clog2(BUS_W);

    localparam logic [BUS_W-1:0] DIR_MASK = 32'hFC06FE03;

    localparam logic [BUS_W-1:0] FIELD_MASK =
        ({{(BUS_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}} << ADDR_LSB) |
        ({{(BUS_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << DATA_LSB);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LATCH = 2'd2
    } wr_state_t;

    // Bus bit driven by each field-write selector; selectors above 4 are unused.
    function automatic logic [IDX_W-1:0] out_bit_idx(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return IDX_W'(0);
            3'd1:    return IDX_W'(1);
            3'd2:    return IDX_W'(17);
            3'd3:    return IDX_W'(18);
            default: return IDX_W'(26);
        endcase
    endfunction

    // Bus bit sampled for each field-read selector.
    function automatic logic [IDX_W-1:0] in_bit_idx(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return IDX_W'(2);
            3'd1:    return IDX_W'(3);
            3'd2:    return IDX_W'(4);
            3'd3:    return IDX_W'(5);
            3'd4:    return IDX_W'(19);
            3'd5:    return IDX_W'(20);
            3'd6:    return IDX_W'(24);
            default: return IDX_W'(25);
        endcase
    endfunction

endpackage

// File: rtl/gpio_wr_encode.sv
// Builds the 7-bit address field {one-hot enables, register index} for a target.
// Target 1 maps to the top enable bit, target N_TGT to the lowest; any other
// number yields no enable and tgt_ok low. Purely combinational.
module gpio_wr_encode
    import gpio_wr_pkg::*;
(
    input  logic [TGT_W-1:0]  tgt,
    input  logic [REG_W-1:0]  reg_idx,
    input  logic              en_phase,
    output logic [ADDR_W-1:0] addr_field,
    output logic              tgt_ok
);

    logic [N_TGT-1:0] en_hot;

    // One comparator per target, highest enable bit for target 1.
    for (genvar g = 0; g < N_TGT; g++) begin : g_en
        assign en_hot[N_TGT-1-g] = (tgt == TGT_W'(g + 1));
    end

    assign tgt_ok     = |en_hot;
    assign addr_field = {en_hot & {N_TGT{en_phase}}, reg_idx};

endmodule

// File: rtl/gpio_wr_timer.sv
// Down-counter for the phase 1 hold time. Loading sets LOAD_VAL-1 so that the
// count reaches zero LOAD_VAL cycles after the load. Assumes LOAD_VAL >= 1.
module gpio_wr_timer #(
    parameter int LOAD_VAL = 17,
    localparam int CNT_W   = (LOAD_VAL > 1) ? $clog2(LOAD_VAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);

    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(LOAD_VAL - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/gpio_wr_pinreg.sv
// Output pin register with masked update: bits under upd_mask take upd_val,
// all others hold. Clears to zero on reset.
module gpio_wr_pinreg
    import gpio_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [BUS_W-1:0] upd_mask,
    input  logic [BUS_W-1:0] upd_val,
    output logic [BUS_W-1:0] q
);

    // Apply a masked read-modify-write when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (upd_en)
            q <= (q & ~upd_mask) | (upd_val & upd_mask);
    end

endmodule

// File: rtl/gpio_wr_master.sv
// Two-phase register write master on a 32-bit GPIO bus. A request is placed as
// index+data with enables low for SETUP_CYC cycles, then with one enable high
// for one cycle before completion. Single-bit field writes are accepted only
// when idle and no register request is pending. Assumes SETUP_CYC >= 1.
module gpio_wr_master
    import gpio_wr_pkg::*;
#(
    parameter int SETUP_CYC = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TGT_W-1:0]  req_target,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_done,
    output logic              wr_err,
    input  logic              fw_valid,
    output logic              fw_ready,
    input  logic [SEL_W-1:0]  fw_sel,
    input  logic              fw_value,
    input  logic [SEL_W-1:0]  fr_sel,
    output logic              fr_value,
    input  logic [BUS_W-1:0]  gpio_in,
    output logic [BUS_W-1:0]  gpio_out,
    output logic [BUS_W-1:0]  gpio_oe
);

    wr_state_t         state;
    logic [TGT_W-1:0]  lat_tgt;
    logic [REG_W-1:0]  lat_reg;
    logic [DATA_W-1:0] lat_data;

    logic              idle;
    logic              accept;
    logic              start;
    logic              fw_take;
    logic [TGT_W-1:0]  enc_tgt;
    logic [REG_W-1:0]  enc_reg;
    logic [DATA_W-1:0] enc_data;
    logic [ADDR_W-1:0] enc_addr;
    logic              enc_ok;
    logic              tmr_zero;
    logic              upd_en;
    logic [BUS_W-1:0]  upd_mask;
    logic [BUS_W-1:0]  upd_val;
    logic [BUS_W-1:0]  pin_q;
    logic [BUS_W-1:0]  field_val;
    logic [IDX_W-1:0]  fw_idx;

    assign idle      = (state == ST_IDLE);
    assign req_ready = idle;
    assign accept    = req_valid && req_ready;
    assign fw_ready  = idle && !req_valid;
    assign fw_take   = fw_valid && fw_ready && (fw_sel <= SEL_W'(N_TGT));
    assign fw_idx    = out_bit_idx(fw_sel);

    // Encoder sees the live request when idle and the latched one afterwards.
    assign enc_tgt  = idle ? req_target : lat_tgt;
    assign enc_reg  = idle ? req_reg    : lat_reg;
    assign enc_data = idle ? req_data   : lat_data;
    assign start    = accept && enc_ok;

    gpio_wr_encode u_enc (
        .tgt        (enc_tgt),
        .reg_idx    (enc_reg),
        .en_phase   (!idle),
        .addr_field (enc_addr),
        .tgt_ok     (enc_ok)
    );

    gpio_wr_timer #(.LOAD_VAL(SETUP_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .zero  (tmr_zero)
    );

    // Place the encoded address and data fields into a bus-wide word.
    always_comb begin
        field_val = '0;
        field_val[ADDR_LSB +: ADDR_W] = enc_addr;
        field_val[DATA_LSB +: DATA_W] = enc_data;
    end

    // Choose which masked pin update, if any, happens this cycle.
    always_comb begin
        upd_en   = 1'b0;
        upd_mask = '0;
        upd_val  = '0;
        if (start || (state == ST_SETUP && tmr_zero)) begin
            upd_en   = 1'b1;
            upd_mask = FIELD_MASK;
            upd_val  = field_val;
        end else if (fw_take) begin
            upd_en           = 1'b1;
            upd_mask[fw_idx] = 1'b1;
            upd_val[fw_idx]  = fw_value;
        end
    end

    gpio_wr_pinreg u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_mask (upd_mask),
        .upd_val  (upd_val),
        .q        (pin_q)
    );

    // Sequence state and capture of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_tgt  <= '0;
            lat_reg  <= '0;
            lat_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_SETUP;
                    lat_tgt  <= req_target;
                    lat_reg  <= req_reg;
                    lat_data <= req_data;
                end
                ST_SETUP: if (tmr_zero) state <= ST_LATCH;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion and refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_done <= 1'b0;
            wr_err  <= 1'b0;
        end else begin
            wr_done <= (state == ST_LATCH);
            wr_err  <= accept && !enc_ok;
        end
    end

    assign gpio_out = pin_q & DIR_MASK;
    assign gpio_oe  = DIR_MASK;
    assign fr_value = gpio_in[in_bit_idx(fr_sel)];

endmodule

// File: rtl/gpio_wr_master_chk.sv
// Protocol checker for gpio_wr_master, attached by bind. Observes ports only.
module gpio_wr_master_chk
    import gpio_wr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TGT_W-1:0]  req_target,
    input logic              wr_done,
    input logic              wr_err,
    input logic              fw_ready,
    input logic [BUS_W-1:0]  gpio_out
);

    logic good_tgt;
    assign good_tgt = (req_target != '0) && (req_target <= TGT_W'(N_TGT));

    a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpio_out[15:12]));

    a_r2_phase1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && good_tgt) |=> (gpio_out[15:12] == 4'b0));

    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && good_tgt) |=> !req_ready);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    a_r5_err_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($stable(gpio_out) && !wr_done));

    a_r8_fw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !fw_ready);

endmodule

bind gpio_wr_master gpio_wr_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_target (req_target),
    .wr_done    (wr_done),
    .wr_err     (wr_err),
    .fw_ready   (fw_ready),
    .gpio_out   (gpio_out)
);

// File: tb/gpio_wr_master_tb.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled on
// the falling edge.
module gpio_wr_master_tb;

    localparam int S = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_target = '0;
    logic [2:0]  req_reg = '0;
    logic [4:0]  req_data = '0;
    logic        fw_valid = 1'b0;
    logic [2:0]  fw_sel = '0;
    logic        fw_value = 1'b0;
    logic [2:0]  fr_sel = '0;
    logic [31:0] gpio_in = '0;
    logic        req_ready, wr_done, wr_err, fw_ready, fr_value;
    logic [31:0] gpio_out, gpio_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_out = '0;

    always #5 clk = ~clk;

    gpio_wr_master #(.SETUP_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_target(req_target), .req_reg(req_reg), .req_data(req_data),
        .wr_done(wr_done), .wr_err(wr_err),
        .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_sel(fw_sel), .fw_value(fw_value),
        .fr_sel(fr_sel), .fr_value(fr_value),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] with_fields(input logic [31:0] base, input logic [6:0] addr, input logic [4:0] d);
        logic [31:0] v = base;
        v[15:9]  = addr;
        v[31:27] = d;
        return v;
    endfunction

    // R1: reset state.
    task automatic t_reset();
        @(negedge clk);
        chk(gpio_out == 32'h0, "R1 gpio_out", gpio_out, 32'h0);
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
        chk(wr_done == 1'b0 && wr_err == 1'b0, "R1 done/err", {30'b0, wr_done, wr_err}, 32'h0);
    endtask

    // R2 R3 R4 R6 R8 R11: one full write, optionally offering a blocked field write.
    task automatic t_write(input logic [2:0] t, input logic [2:0] r, input logic [4:0] d, input bit poke_fw);
        logic [31:0] p1, p2;
        p1 = with_fields(exp_out, {4'b0, r}, d);
        p2 = p1;
        p2[16 - int'(t)] = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_target = t; req_reg = r; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(gpio_out == p1, "R2 phase1 fields", gpio_out, p1);
        chk(req_ready == 1'b0, "R4 ready low", 32'(req_ready), 32'h0);
        if (poke_fw) begin
            fw_valid = 1'b1; fw_sel = 3'd0; fw_value = ~exp_out[0];
            @(negedge clk);
            chk(fw_ready == 1'b0, "R8 fw_ready low", 32'(fw_ready), 32'h0);
            chk(gpio_out == p1, "R8 bus untouched", gpio_out, p1);
            fw_valid = 1'b0;
            repeat (S - 2) @(negedge clk);
        end else begin
            repeat (S - 1) @(negedge clk);
        end
        chk(gpio_out == p1, "R2 phase1 held", gpio_out, p1);
        @(negedge clk);
        chk(gpio_out == p2, "R3 phase2 enable", gpio_out, p2);
        chk(req_ready == 1'b0, "R4 ready low in phase2", 32'(req_ready), 32'h0);
        chk(wr_done == 1'b0, "R4 done early", 32'(wr_done), 32'h0);
        @(negedge clk);
        chk(wr_done == 1'b1 && req_ready == 1'b1, "R4 done+ready", {30'b0, wr_done, req_ready}, 32'h3);
        @(negedge clk);
        chk(wr_done == 1'b0, "R4 done single", 32'(wr_done), 32'h0);
        chk(gpio_out == p2, "R11 enable persists, R6 others kept", gpio_out, p2);
        exp_out = p2;
    endtask

    // R5: refused target number.
    task automatic t_bad(input logic [2:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_target = t; req_reg = 3'd5; req_data = 5'h1F;
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr_err == 1'b1, "R5 err pulse", 32'(wr_err), 32'h1);
        chk(req_ready == 1'b1 && wr_done == 1'b0, "R5 ready/done", {30'b0, req_ready, wr_done}, 32'h2);
        chk(gpio_out == exp_out, "R5 bus unchanged", gpio_out, exp_out);
        @(negedge clk);
        chk(wr_err == 1'b0, "R5 err single", 32'(wr_err), 32'h0);
        chk(gpio_out == exp_out, "R5 bus still unchanged", gpio_out, exp_out);
    endtask

    // R7: single-bit field write.
    task automatic t_field(input logic [2:0] sel, input logic v);
        int b;
        b = (sel == 3'd0) ? 0 : (sel == 3'd1) ? 1 : (sel == 3'd2) ? 17 :
            (sel == 3'd3) ? 18 : (sel == 3'd4) ? 26 : -1;
        @(negedge clk);
        fw_valid = 1'b1; fw_sel = sel; fw_value = v;
        @(negedge clk);
        fw_valid = 1'b0;
        if (b >= 0) exp_out[b] = v;
        chk(gpio_out == exp_out, "R7 field write", gpio_out, exp_out);
    endtask

    // R8: register request pending in idle blocks field writes.
    task automatic t_fw_vs_req();
        @(negedge clk);
        req_valid = 1'b1; req_target = 3'd6; fw_valid = 1'b1; fw_sel = 3'd1; fw_value = ~exp_out[1];
        #1;
        chk(fw_ready == 1'b0, "R8 fw_ready low with req_valid", 32'(fw_ready), 32'h0);
        @(negedge clk);
        req_valid = 1'b0; fw_valid = 1'b0;
        chk(gpio_out == exp_out, "R8 field write not applied", gpio_out, exp_out);
    endtask

    // R9 R10: field read and direction mask.
    task automatic t_read();
        int bits [8] = '{2, 3, 4, 5, 19, 20, 24, 25};
        for (int i = 0; i < 8; i++) begin
            gpio_in = 32'h0; gpio_in[bits[i]] = 1'b1; fr_sel = 3'(i);
            #1;
            chk(fr_value == 1'b1, "R9 read one", 32'(fr_value), 32'h1);
            gpio_in = ~gpio_in;
            #1;
            chk(fr_value == 1'b0, "R9 read zero", 32'(fr_value), 32'h0);
        end
        chk(gpio_oe == 32'hFC06FE03, "R10 direction mask", gpio_oe, 32'hFC06FE03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_field(3'd0, 1'b1);
        t_field(3'd3, 1'b1);
        t_field(3'd4, 1'b1);
        t_field(3'd6, 1'b1);
        t_write(3'd1, 3'd2, 5'h15, 1'b0);
        t_write(3'd4, 3'd7, 5'h0A, 1'b1);
        t_write(3'd2, 3'd0, 5'h1F, 1'b0);
        t_write(3'd3, 3'd5, 5'h00, 1'b0);
        t_bad(3'd0);
        t_bad(3'd5);
        t_bad(3'd7);
        t_fw_vs_req();
        t_field(3'd0, 1'b0);
        t_field(3'd2, 1'b1);
        t_read();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule